// File: doc/BRIEF.md
# Shader Flow Control Sequencer

This block produces the instruction fetch address for a small vector shader core. An external decoder splits each fetched word into fields (operation, destination, span, condition mode and reference bits, uniform selectors) and presents them with a valid strobe. The sequencer accepts one instruction per cycle, resolves jumps, subroutine calls, if/else bodies and counted loops, and reports when the program has reached its end.

Calls, if/else bodies and loops share one scope stack. Each entry records where its body starts, the address at which it ends, where execution resumes afterwards, how many extra passes remain and the step added to the loop counter after each pass. No return instruction exists. Whenever the fetch address equals the end address of the innermost scope, the sequencer spends one cycle closing that scope instead of taking an instruction, so several scopes that end at the same address close one per cycle.

A start pulse loads the entry address, clears the two condition-code bits and empties the stack. The condition-code bits are written from the arithmetic side through a write port. The integer uniform bank supplies loop parameters and the boolean uniform bank supplies the enables for the uniform-gated forms.

Top module: `shdr_flow_seq`

## Requirements
- R1: After reset `halted`, `instr_ready`, `stall`, `ovf_err` and `loop_ctr` are 0. A `start` pulse makes `fetch_pc` equal `entry_pc` one cycle later, clears both condition-code bits and empties the stack. `start` has priority over everything else.
- R2: An accepted NOP (`instr_op` 0), or any unused code 10 to 15, advances `fetch_pc` by one.
- R3: JMPC (op 2) loads `dst_pc` when the condition of R4 holds. JMPU (op 3) loads `dst_pc` when `bool_bank[bool_sel]` is 1. Otherwise both advance by one.
- R4: The condition is built from two tests. The first test is true when `ref_x` equals condition bit 0. The second test is true when `ref_y` equals condition bit 1. `cond_mode` combines them: 0 is OR, 1 is AND, 2 uses the first test only and 3 uses the second test only. A `cc_wr_en` cycle writes `cc_wr_val` into the condition bits, and the new value is seen by the next instruction.
- R5: CALL (op 4, always), CALLU (op 5, boolean uniform) and CALLC (op 6, condition) jump to `dst_pc` and push a scope that ends at `dst_pc+span` and resumes at the call address plus one. When not enabled they advance by one.
- R6: When the stack is not empty and `fetch_pc` equals the innermost end address, that cycle raises `stall`, lowers `instr_ready` and consumes no instruction. Scopes that end at the same address close on consecutive cycles.
- R7: IFU (op 7, boolean uniform) and IFC (op 8, condition) choose between two bodies. If the test is true, the body runs from the next address up to but excluding `dst_pc`. If it is false, the body is the `span` instructions starting at `dst_pc`. Both cases resume at `dst_pc+span`.
- R8: LOOP (op 9) reads the entry `int_sel` of the integer bank. Bits 7:0 of that entry give the repeat count r, bits 15:8 give the initial counter value, and bits 23:16 give the step. The loop loads `loop_ctr` with the initial value. The body runs from the next address through `dst_pc` r+1 times. `loop_ctr` increases by the step, modulo 256, after every pass. Execution then resumes at `dst_pc+1`.
- R9: END (op 1) sets `halted`. `fetch_pc` then stays at the END address until the next `start`.
- R10: A push while the stack holds `DEPTH` entries sets `ovf_err`. The instruction is then otherwise ignored: it advances by one, leaves the stack and `loop_ctr` unchanged, and `ovf_err` stays set until reset.
- R11: `instr_ready` is high only while running and no scope is closing. It is low before the first `start` and while `halted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a program at `entry_pc` |
| entry_pc | input | PC_W | Program entry address |
| cc_wr_en | input | 1 | Write the condition-code bits |
| cc_wr_val | input | 2 | Condition-code value to write |
| instr_valid | input | 1 | Decoded instruction present |
| instr_ready | output | 1 | Instruction accepted this cycle |
| instr_op | input | 4 | Flow operation code |
| cond_mode | input | 2 | Condition combine mode |
| ref_x | input | 1 | Reference for condition bit 0 |
| ref_y | input | 1 | Reference for condition bit 1 |
| dst_pc | input | PC_W | Destination / else / loop-end address |
| span | input | CNT_W | Instruction count of call or else body |
| bool_sel | input | log2(NB) | Boolean uniform index |
| int_sel | input | log2(NI) | Integer uniform index |
| bool_bank | input | NB | Boolean uniform bank |
| int_bank | input | 24*NI | Integer uniform bank, 24 bits per entry |
| fetch_pc | output | PC_W | Current fetch address |
| loop_ctr | output | 8 | Loop-counter register |
| halted | output | 1 | END reached |
| stall | output | 1 | Scope-closing cycle |
| ovf_err | output | 1 | Sticky stack-overflow flag |

## Verification
The bench builds the sequencer with an 8-bit address, a four-entry stack and four-entry uniform banks. The shallow stack lets a short chain of five nested calls reach overflow. The 256-word address space lets the bench hold a whole program image that it serves from `fetch_pc`. The bench sweeps all 64 combinations of condition bits, reference bits and combine mode. It also sweeps repeat counts 0 to 3 against two steps, with a start value chosen so the loop counter wraps. It checks nested scopes that close at one address through the stall count.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;

    localparam logic [3:0] OP_NOP   = 4'd0;
    localparam logic [3:0] OP_END   = 4'd1;
    localparam logic [3:0] OP_JMPC  = 4'd2;
    localparam logic [3:0] OP_JMPU  = 4'd3;
    localparam logic [3:0] OP_CALL  = 4'd4;
    localparam logic [3:0] OP_CALLU = 4'd5;
    localparam logic [3:0] OP_CALLC = 4'd6;
    localparam logic [3:0] OP_IFU   = 4'd7;
    localparam logic [3:0] OP_IFC   = 4'd8;
    localparam logic [3:0] OP_LOOP  = 4'd9;

    localparam logic [1:0] CM_OR  = 2'd0;
    localparam logic [1:0] CM_AND = 2'd1;
    localparam logic [1:0] CM_X   = 2'd2;
    localparam logic [1:0] CM_Y   = 2'd3;

    localparam int UNI_BITS = 24;

endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
    import flow_seq_pkg::*;
(
    input  logic [1:0] cc,
    input  logic       ref_x,
    input  logic       ref_y,
    input  logic [1:0] mode,
    output logic       pass
);

    logic hit_x;
    logic hit_y;

    always_comb begin
        hit_x = (ref_x == cc[0]);
        hit_y = (ref_y == cc[1]);
        unique case (mode)
            CM_OR:   pass = hit_x | hit_y;
            CM_AND:  pass = hit_x & hit_y;
            CM_X:    pass = hit_x;
            default: pass = hit_y;
        endcase
    end

endmodule

// File: rtl/flow_scope_stack.sv
module flow_scope_stack #(
    parameter int DEPTH = 16,
    parameter int PC_W  = 9,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    input  logic             dec,
    input  logic [PC_W-1:0]  push_start,
    input  logic [PC_W-1:0]  push_end,
    input  logic [PC_W-1:0]  push_ret,
    input  logic [CNT_W-1:0] push_rep,
    input  logic [7:0]       push_inc,
    output logic [PC_W-1:0]  top_start,
    output logic [PC_W-1:0]  top_end,
    output logic [PC_W-1:0]  top_ret,
    output logic [CNT_W-1:0] top_rep,
    output logic [7:0]       top_inc,
    output logic             empty,
    output logic             full
);

    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [PC_W-1:0]  start_a;
        logic [PC_W-1:0]  end_a;
        logic [PC_W-1:0]  ret_a;
        logic [CNT_W-1:0] rep;
        logic [7:0]       inc;
    } scope_t;

    scope_t            ent_q [DEPTH];
    scope_t            ent_d [DEPTH];
    logic [PTR_W-1:0]  cnt_q;
    logic [PTR_W-1:0]  cnt_d;
    logic [PTR_W-1:0]  top_ptr;
    logic [IDX_W-1:0]  top_idx;
    logic [IDX_W-1:0]  new_idx;

    assign top_ptr = cnt_q - 1'b1;
    assign top_idx = top_ptr[IDX_W-1:0];
    assign new_idx = cnt_q[IDX_W-1:0];
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == PTR_W'(DEPTH));

    assign top_start = ent_q[top_idx].start_a;
    assign top_end   = ent_q[top_idx].end_a;
    assign top_ret   = ent_q[top_idx].ret_a;
    assign top_rep   = ent_q[top_idx].rep;
    assign top_inc   = ent_q[top_idx].inc;

    always_comb begin
        ent_d = ent_q;
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (push && !full) begin
            ent_d[new_idx].start_a = push_start;
            ent_d[new_idx].end_a   = push_end;
            ent_d[new_idx].ret_a   = push_ret;
            ent_d[new_idx].rep     = push_rep;
            ent_d[new_idx].inc     = push_inc;
            cnt_d = cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_d = cnt_q - 1'b1;
        end else if (dec && !empty) begin
            ent_d[top_idx].rep = ent_q[top_idx].rep - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            cnt_q <= cnt_d;
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    // R10
    push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    // R6
    pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop || dec) |-> !empty);

    // R6
    pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clear && !empty) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/shdr_flow_seq.sv
module shdr_flow_seq
    import flow_seq_pkg::*;
#(
    parameter int PC_W  = 9,
    parameter int DEPTH = 16,
    parameter int NB    = 16,
    parameter int NI    = 4,
    parameter int CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [PC_W-1:0]        entry_pc,
    input  logic                   cc_wr_en,
    input  logic [1:0]             cc_wr_val,
    input  logic                   instr_valid,
    output logic                   instr_ready,
    input  logic [3:0]             instr_op,
    input  logic [1:0]             cond_mode,
    input  logic                   ref_x,
    input  logic                   ref_y,
    input  logic [PC_W-1:0]        dst_pc,
    input  logic [CNT_W-1:0]       span,
    input  logic [$clog2(NB)-1:0]  bool_sel,
    input  logic [$clog2(NI)-1:0]  int_sel,
    input  logic [NB-1:0]          bool_bank,
    input  logic [NI*UNI_BITS-1:0] int_bank,
    output logic [PC_W-1:0]        fetch_pc,
    output logic [7:0]             loop_ctr,
    output logic                   halted,
    output logic                   stall,
    output logic                   ovf_err
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            run;
        logic            halt;
        logic [1:0]      cc;
        logic [7:0]      lc;
        logic            ovf;
    } seq_t;

    seq_t st_q;
    seq_t st_d;

    // integer uniform bank split into fields
    logic [CNT_W-1:0] u_rep  [NI];
    logic [7:0]       u_init [NI];
    logic [7:0]       u_step [NI];

    for (genvar g = 0; g < NI; g++) begin : g_ibank
        assign u_rep[g]  = CNT_W'(int_bank[g*UNI_BITS +: 8]);
        assign u_init[g] = int_bank[g*UNI_BITS + 8 +: 8];
        assign u_step[g] = int_bank[g*UNI_BITS + 16 +: 8];
    end

    logic             cond_ok;
    logic             buni;
    logic             stk_clr, stk_push, stk_pop, stk_dec;
    logic [PC_W-1:0]  p_start, p_end, p_ret;
    logic [CNT_W-1:0] p_rep;
    logic [7:0]       p_inc;
    logic [PC_W-1:0]  t_start, t_end, t_ret;
    logic [CNT_W-1:0] t_rep;
    logic [7:0]       t_inc;
    logic             stk_empty, stk_full;
    logic             scope_end;
    logic             want_push;
    logic [PC_W-1:0]  tgt_pc;
    logic [PC_W-1:0]  pc_inc;
    logic [PC_W-1:0]  span_pc;
    logic             load_lc;

    flow_cond_eval u_cond (
        .cc    (st_q.cc),
        .ref_x (ref_x),
        .ref_y (ref_y),
        .mode  (cond_mode),
        .pass  (cond_ok)
    );

    flow_scope_stack #(
        .DEPTH (DEPTH),
        .PC_W  (PC_W),
        .CNT_W (CNT_W)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (stk_clr),
        .push       (stk_push),
        .pop        (stk_pop),
        .dec        (stk_dec),
        .push_start (p_start),
        .push_end   (p_end),
        .push_ret   (p_ret),
        .push_rep   (p_rep),
        .push_inc   (p_inc),
        .top_start  (t_start),
        .top_end    (t_end),
        .top_ret    (t_ret),
        .top_rep    (t_rep),
        .top_inc    (t_inc),
        .empty      (stk_empty),
        .full       (stk_full)
    );

    assign buni      = bool_bank[bool_sel];
    assign pc_inc    = st_q.pc + 1'b1;
    assign span_pc   = PC_W'(span);
    assign scope_end = st_q.run && !stk_empty && (st_q.pc == t_end);

    always_comb begin
        st_d        = st_q;
        stk_clr     = 1'b0;
        stk_push    = 1'b0;
        stk_pop     = 1'b0;
        stk_dec     = 1'b0;
        p_start     = '0;
        p_end       = '0;
        p_ret       = '0;
        p_rep       = '0;
        p_inc       = '0;
        want_push   = 1'b0;
        tgt_pc      = pc_inc;
        load_lc     = 1'b0;
        instr_ready = 1'b0;
        stall       = 1'b0;

        if (cc_wr_en) begin
            st_d.cc = cc_wr_val;
        end

        if (start) begin
            st_d.pc   = entry_pc;
            st_d.run  = 1'b1;
            st_d.halt = 1'b0;
            st_d.cc   = 2'b00;
            stk_clr   = 1'b1;
        end else if (st_q.run) begin
            if (scope_end) begin
                stall   = 1'b1;
                st_d.lc = st_q.lc + t_inc;
                if (t_rep == '0) begin
                    stk_pop = 1'b1;
                    st_d.pc = t_ret;
                end else begin
                    stk_dec = 1'b1;
                    st_d.pc = t_start;
                end
            end else begin
                instr_ready = 1'b1;
                if (instr_valid) begin
                    st_d.pc = pc_inc;
                    unique case (instr_op)
                        OP_END: begin
                            st_d.halt = 1'b1;
                            st_d.run  = 1'b0;
                            st_d.pc   = st_q.pc;
                        end
                        OP_JMPC: if (cond_ok) st_d.pc = dst_pc;
                        OP_JMPU: if (buni)    st_d.pc = dst_pc;
                        OP_CALL, OP_CALLU, OP_CALLC: begin
                            want_push = (instr_op == OP_CALL) ||
                                        (instr_op == OP_CALLU && buni) ||
                                        (instr_op == OP_CALLC && cond_ok);
                            p_start = dst_pc;
                            p_end   = dst_pc + span_pc;
                            p_ret   = pc_inc;
                            tgt_pc  = dst_pc;
                        end
                        OP_IFU, OP_IFC: begin
                            want_push = 1'b1;
                            p_ret     = dst_pc + span_pc;
                            if ((instr_op == OP_IFU) ? buni : cond_ok) begin
                                p_start = pc_inc;
                                p_end   = dst_pc;
                                tgt_pc  = pc_inc;
                            end else begin
                                p_start = dst_pc;
                                p_end   = dst_pc + span_pc;
                                tgt_pc  = dst_pc;
                            end
                        end
                        OP_LOOP: begin
                            want_push = 1'b1;
                            load_lc   = 1'b1;
                            p_start   = pc_inc;
                            p_end     = dst_pc + 1'b1;
                            p_ret     = dst_pc + 1'b1;
                            p_rep     = u_rep[int_sel];
                            p_inc     = u_step[int_sel];
                            tgt_pc    = pc_inc;
                        end
                        default: ;
                    endcase

                    if (want_push) begin
                        if (stk_full) begin
                            st_d.ovf = 1'b1;
                            st_d.pc  = pc_inc;
                        end else begin
                            stk_push = 1'b1;
                            st_d.pc  = tgt_pc;
                            if (load_lc) begin
                                st_d.lc = u_init[int_sel];
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_pc = st_q.pc;
    assign loop_ctr = st_q.lc;
    assign halted   = st_q.halt;
    assign ovf_err  = st_q.ovf;

    // R6
    stall_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !instr_ready);

    // R11
    halted_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !instr_ready);

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> (halted && $stable(fetch_pc)));

    // R1
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (fetch_pc == $past(entry_pc) && !halted));

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    // R2
    nop_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && instr_op == OP_NOP && !start)
        |=> (fetch_pc == PC_W'($past(fetch_pc) + 1'b1)));

    // R8
    loop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (loop_ctr == 8'($past(loop_ctr) + $past(t_inc))));

endmodule

// File: tb/shdr_flow_seq_bench.sv
module shdr_flow_seq_bench;

    localparam int CLK_NS = 10;
    localparam int PC_W   = 8;
    localparam int DEPTH  = 4;
    localparam int NB     = 4;
    localparam int NI     = 4;

    localparam logic [3:0] K_NOP = 4'd0, K_END = 4'd1, K_JMPC = 4'd2, K_JMPU = 4'd3,
                           K_CALL = 4'd4, K_CALLU = 4'd5, K_CALLC = 4'd6,
                           K_IFU = 4'd7, K_IFC = 4'd8, K_LOOP = 4'd9;

    typedef struct packed {
        logic [3:0] op;
        logic [1:0] mode;
        logic       rx;
        logic       ry;
        logic [7:0] dst;
        logic [7:0] cnt;
        logic [1:0] bsel;
        logic [1:0] isel;
    } prog_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [PC_W-1:0] entry_pc = '0;
    logic cc_wr_en = 1'b0;
    logic [1:0] cc_wr_val = '0;
    logic instr_valid = 1'b0;
    logic instr_ready;
    logic [3:0] instr_op = '0;
    logic [1:0] cond_mode = '0;
    logic ref_x = 1'b0, ref_y = 1'b0;
    logic [PC_W-1:0] dst_pc = '0;
    logic [7:0] span = '0;
    logic [1:0] bool_sel = '0, int_sel = '0;
    logic [NB-1:0] bool_bank = 4'b0101;
    logic [NI*24-1:0] int_bank = '0;
    logic [PC_W-1:0] fetch_pc;
    logic [7:0] loop_ctr;
    logic halted, stall, ovf_err;

    prog_t mem [256];
    int hits [256];
    int stalls;
    int total = 0;
    int fails = 0;
    int cyc = 0;

    always #(CLK_NS/2) clk = ~clk;

    shdr_flow_seq #(.PC_W(PC_W), .DEPTH(DEPTH), .NB(NB), .NI(NI), .CNT_W(8)) u_shdr_flow_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .entry_pc(entry_pc),
        .cc_wr_en(cc_wr_en), .cc_wr_val(cc_wr_val),
        .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_op(instr_op),
        .cond_mode(cond_mode), .ref_x(ref_x), .ref_y(ref_y), .dst_pc(dst_pc),
        .span(span), .bool_sel(bool_sel), .int_sel(int_sel),
        .bool_bank(bool_bank), .int_bank(int_bank),
        .fetch_pc(fetch_pc), .loop_ctr(loop_ctr), .halted(halted),
        .stall(stall), .ovf_err(ovf_err)
    );

    task automatic summary();
        $display("  %0d/%0d checks passed", total - fails, total);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int a = 0; a < 256; a++) begin
            mem[a] = '0;
            mem[a].op = K_END;
        end
    endtask

    task automatic put(input int a, input logic [3:0] op, input int dst, input int cnt);
        mem[a] = '0;
        mem[a].op = op;
        mem[a].dst = 8'(dst);
        mem[a].cnt = 8'(cnt);
    endtask

    task automatic drive_cur();
        prog_t e;
        e = mem[fetch_pc];
        instr_valid = 1'b1;
        instr_op = e.op;
        cond_mode = e.mode;
        ref_x = e.rx;
        ref_y = e.ry;
        dst_pc = e.dst;
        span = e.cnt;
        bool_sel = e.bsel;
        int_sel = e.isel;
    endtask

    task automatic run_prog(input int entry, input bit cc_do, input logic [1:0] cc_v);
        for (int a = 0; a < 256; a++) hits[a] = 0;
        stalls = 0;
        @(negedge clk);
        entry_pc = 8'(entry);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            if (halted) break;
            drive_cur();
            cc_wr_en = cc_do && (c == 0);
            cc_wr_val = cc_v;
            #1;
            if (stall) stalls++;
            if (instr_ready && instr_valid) hits[fetch_pc]++;
            @(negedge clk);
        end
        cc_wr_en = 1'b0;
        chk(halted == 1'b1, "R9 program reached END", int'(halted), 1);
    endtask

    initial begin
        // R1 / R11 reset state
        #(CLK_NS*2 + 2);
        chk(halted == 0 && instr_ready == 0 && stall == 0 && ovf_err == 0 && loop_ctr == 0,
            "R1 R11 reset outputs", int'({halted, instr_ready, stall, ovf_err}) + int'(loop_ctr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(instr_ready == 0, "R11 idle before start", int'(instr_ready), 0);

        // R2 / R1 / R9 straight-line run from an entry offset
        clear_mem();
        for (int a = 10; a < 15; a++) put(a, K_NOP, 0, 0);
        put(12, 4'd13, 0, 0);
        run_prog(10, 0, 2'b00);
        for (int a = 10; a < 15; a++) chk(hits[a] == 1, "R2 sequential hit", hits[a], 1);
        chk(fetch_pc == 15, "R9 pc held at END", int'(fetch_pc), 15);
        repeat (3) @(negedge clk);
        chk(fetch_pc == 15 && instr_ready == 0, "R9 R11 halted holds", int'(fetch_pc), 15);

        // R4 / R3 exhaustive condition sweep
        for (int cc = 0; cc < 4; cc++) begin
            for (int rr = 0; rr < 4; rr++) begin
                for (int m = 0; m < 4; m++) begin
                    bit hx, hy, pass;
                    clear_mem();
                    put(0, K_NOP, 0, 0);
                    put(1, K_JMPC, 20, 0);
                    mem[1].mode = 2'(m);
                    mem[1].rx = rr[0];
                    mem[1].ry = rr[1];
                    run_prog(0, 1, 2'(cc));
                    hx = (rr[0] == cc[0]);
                    hy = (rr[1] == cc[1]);
                    pass = (m == 0) ? (hx | hy) : (m == 1) ? (hx & hy) : (m == 2) ? hx : hy;
                    chk(fetch_pc == (pass ? 20 : 2), "R4 R3 JMPC condition",
                        int'(fetch_pc), pass ? 20 : 2);
                end
            end
        end

        // R1 start clears condition bits: JMPC X-only ref_x=0 must be taken
        clear_mem();
        put(0, K_JMPC, 30, 0);
        mem[0].mode = 2'd2;
        run_prog(0, 0, 2'b00);
        chk(fetch_pc == 30, "R1 cc cleared at start", int'(fetch_pc), 30);

        // R3 JMPU over boolean bank 0101
        for (int s = 0; s < 4; s++) begin
            clear_mem();
            put(0, K_JMPU, 30, 0);
            mem[0].bsel = 2'(s);
            run_prog(0, 0, 2'b00);
            chk(fetch_pc == ((s % 2 == 0) ? 30 : 1), "R3 JMPU", int'(fetch_pc), (s % 2 == 0) ? 30 : 1);
        end

        // R5 CALL body at 50..52, return to 1
        clear_mem();
        put(0, K_CALL, 50, 3);
        put(1, K_NOP, 0, 0);
        for (int a = 50; a < 54; a++) put(a, K_NOP, 0, 0);
        run_prog(0, 0, 2'b00);
        chk(hits[50] == 1 && hits[51] == 1 && hits[52] == 1, "R5 call body", hits[51], 1);
        chk(hits[53] == 0, "R5 call end excluded", hits[53], 0);
        chk(hits[1] == 1 && fetch_pc == 2, "R5 call return", int'(fetch_pc), 2);
        chk(stalls == 1, "R6 one closing cycle", stalls, 1);

        // R5 CALLU not enabled (bool bit1=0)
        mem[0].op = K_CALLU;
        mem[0].bsel = 2'd1;
        run_prog(0, 0, 2'b00);
        chk(hits[50] == 0 && hits[1] == 1, "R5 CALLU skipped", hits[50], 0);

        // R5 CALLC enabled (X-only, ref 0, cc 0)
        mem[0].op = K_CALLC;
        mem[0].mode = 2'd2;
        run_prog(0, 0, 2'b00);
        chk(hits[50] == 1 && fetch_pc == 2, "R5 CALLC taken", hits[50], 1);

        // R7 if/else: then 1..4, else 5..6, resume 7
        for (int t = 0; t < 3; t++) begin
            bit taken;
            clear_mem();
            for (int a = 1; a < 7; a++) put(a, K_NOP, 0, 0);
            put(0, (t == 2) ? K_IFC : K_IFU, 5, 2);
            mem[0].bsel = 2'(t);
            mem[0].mode = 2'd3;
            mem[0].ry = 1'b1;
            taken = (t == 0);
            run_prog(0, 0, 2'b00);
            chk(hits[1] == (taken ? 1 : 0) && hits[4] == (taken ? 1 : 0), "R7 then body", hits[4], taken ? 1 : 0);
            chk(hits[5] == (taken ? 0 : 1) && hits[6] == (taken ? 0 : 1), "R7 else body", hits[5], taken ? 0 : 1);
            chk(fetch_pc == 7, "R7 resume", int'(fetch_pc), 7);
        end

        // R8 loop sweep: body 1..2, resume 3
        for (int rep = 0; rep < 4; rep++) begin
            for (int k = 0; k < 2; k++) begin
                int stp, expv;
                stp = (k == 0) ? 1 : 5;
                int_bank = '0;
                int_bank[2*24 +: 24] = {8'(stp), 8'd250, 8'(rep)};
                clear_mem();
                put(0, K_LOOP, 2, 0);
                mem[0].isel = 2'd2;
                put(1, K_NOP, 0, 0);
                put(2, K_NOP, 0, 0);
                run_prog(0, 0, 2'b00);
                expv = (250 + (rep + 1) * stp) % 256;
                chk(hits[1] == rep + 1 && hits[2] == rep + 1, "R8 loop passes", hits[1], rep + 1);
                chk(int'(loop_ctr) == expv, "R8 loop counter", int'(loop_ctr), expv);
                chk(fetch_pc == 3 && stalls == rep + 1, "R8 loop exit", int'(fetch_pc), 3);
            end
        end

        // R6 two scopes closing at address 13
        clear_mem();
        put(0, K_CALL, 10, 3);
        put(1, K_NOP, 0, 0);
        put(10, K_NOP, 0, 0);
        put(11, K_NOP, 0, 0);
        put(12, K_CALL, 30, 1);
        put(13, K_NOP, 0, 0);
        put(30, K_NOP, 0, 0);
        run_prog(0, 0, 2'b00);
        chk(hits[30] == 1 && hits[13] == 0, "R6 nested unwind skips 13", hits[13], 0);
        chk(stalls == 2, "R6 one close per cycle", stalls, 2);
        chk(fetch_pc == 2 && hits[1] == 1, "R6 outer return", int'(fetch_pc), 2);

        // R10 overflow with DEPTH 4
        clear_mem();
        for (int a = 0; a < 4; a++) put(a, K_CALL, a + 1, 50);
        put(4, K_CALL, 40, 3);
        put(40, K_NOP, 0, 0);
        chk(ovf_err == 0, "R10 no overflow yet", int'(ovf_err), 0);
        run_prog(0, 0, 2'b00);
        chk(ovf_err == 1, "R10 overflow flagged", int'(ovf_err), 1);
        chk(fetch_pc == 5 && hits[40] == 0, "R10 push ignored", int'(fetch_pc), 5);
        clear_mem();
        run_prog(0, 0, 2'b00);
        chk(ovf_err == 1, "R10 flag sticky across start", int'(ovf_err), 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ovf_err == 0 && halted == 0, "R1 reset clears flag", int'(ovf_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        summary();
        $finish;
    end

endmodule